// File: doc/BRIEF.md
# Infrared Return-to-Zero Bit Codec

This block sits between a UART core and an infrared transceiver. On the transmit side it turns the UART's level-coded serial bit into a pulse code. A one bit leaves the infrared output low for the whole bit. A zero bit becomes a single high pulse, three sixteenths of a bit long, at the start of the bit. On the receive side it watches the detector and rebuilds a level-coded bit stream for the UART receiver. Any pulse of at least one tick turns the rebuilt bit into a zero for one bit period.

All timing comes from a one-cycle tick strobe at sixteen times the bit rate, which the baud generator supplies. The link is half-duplex. While the transmitter is sending a zero bit, the receive output is held idle, so the block never decodes the echo of its own pulses. An idle-level select input suits detectors whose output idles high and pulses low. A disable input parks both outputs at their idle levels.

Top module: `irsir_codec`

## Requirements
- R1: During and right after reset, `ir_tx` is 0 and `rx_nrz` is 1.
- R2: Tick 0 of a transmitted zero bit is the first tick that samples `tx_nrz` at 0. After the edges of ticks 0, 1 and 2, `ir_tx` is 1. After ticks 3 to 15 it is 0. A pulse never lasts more than 3 ticks, and it starts only on a tick that samples `tx_nrz` low.
- R3: While `tx_nrz` is 1, `ir_tx` stays 0 for the whole bit.
- R4: A new transmit bit starts every 16 ticks. Any change of the `tx_nrz` level starts a new bit at tick 0. Each zero bit in a run of zero bits gives its own pulse.
- R5: The detector pulse level is `ir_rx` XOR `rx_idle_hi`. A tick that samples this level at 1, where the previous tick sampled 0, starts a received zero. `rx_nrz` is then 0 after that tick and after the next 15 ticks. It returns to 1 at the 16th tick, unless a new pulse starts on that tick.
- R6: A pulse that is active at only one tick is enough to decode a zero bit.
- R7: With `rx_idle_hi`=0 the detector idles low and pulses high. With `rx_idle_hi`=1 it idles high and pulses low.
- R8: At a tick where `tx_nrz` is 0, or while the encoder is inside a zero bit, `rx_nrz` is forced to 1 and pulses on `ir_rx` are ignored.
- R9: While `enable` is 0, `ir_tx` is 0 and `rx_nrz` is 1 from the next clock cycle on. After `enable` returns to 1, the codec starts again from its idle state.
- R10: `ir_rx` passes through a two-stage synchronizer. While `enable` is 1, both outputs change only at the clock edge of a tick, never between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Codec enable; 0 parks the outputs at idle |
| rx_idle_hi | input | 1 | 1: detector idles high and pulses low |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| tx_nrz | input | 1 | Level-coded transmit bit from the UART |
| ir_tx | output | 1 | Pulse-coded drive to the infrared emitter |
| ir_rx | input | 1 | Infrared detector output |
| rx_nrz | output | 1 | Rebuilt level-coded receive bit to the UART |

## Verification
Both outputs are registered. Each one is due at the clock edge of the tick that samples the stimulus. The bench therefore presents each tick's inputs seven cycles before the strobe, which clears the two-stage receive synchronizer. It compares the expected levels for that tick at the falling clock edge that follows the strobe. The disable checks are the exception: they sample one cycle after `enable` falls. A probe between ticks confirms that a settled detector pulse has not moved `rx_nrz` before the strobe.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  parameter int unsigned OSR_DEF   = 16;
  parameter int unsigned PULSE_DEF = 3;
  parameter int unsigned SYNC_DEF  = 2;

  typedef enum logic { RX_IDLE = 1'b0, RX_ZERO = 1'b1 } rx_state_e;
endpackage

// File: rtl/irsir_sync.sv
module irsir_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/irsir_enc.sv
module irsir_enc #(
  parameter int unsigned OSR   = 16,
  parameter int unsigned PULSE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic nrz_i,
  output logic ir_o,
  output logic zero_bit_o
);
  localparam int unsigned PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0] PH_PULSE = PH_W'(PULSE);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            bit_q, bit_d;
  logic            out_q, out_d;

  always_comb begin
    ph_d  = ph_q;
    bit_d = bit_q;
    out_d = out_q;
    if (!en_i) begin
      ph_d  = PH_LAST;
      bit_d = 1'b1;
      out_d = 1'b0;
    end else if (tick_i) begin
      if ((nrz_i != bit_q) || (ph_q == PH_LAST)) begin
        ph_d  = '0;
        bit_d = nrz_i;
      end else begin
        ph_d = ph_q + 1'b1;
      end
      out_d = !bit_d && (ph_d < PH_PULSE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_LAST;
      bit_q <= 1'b1;
      out_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      bit_q <= bit_d;
      out_q <= out_d;
    end
  end

  assign ir_o       = out_q;
  assign zero_bit_o = !bit_q;
endmodule

// File: rtl/irsir_dec.sv
module irsir_dec
  import irsir_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic pulse_i,
  input  logic blank_i,
  output logic nrz_o
);
  localparam int unsigned PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] CNT_LAST = PH_W'(OSR - 1);

  rx_state_e       st_q, st_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic            prev_q, prev_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    prev_d = prev_q;
    if (!en_i || (tick_i && blank_i)) begin
      st_d   = RX_IDLE;
      cnt_d  = '0;
      prev_d = pulse_i;
    end else if (tick_i) begin
      prev_d = pulse_i;
      if (pulse_i && !prev_q) begin
        st_d  = RX_ZERO;
        cnt_d = '0;
      end else if (st_q == RX_ZERO) begin
        if (cnt_q == CNT_LAST) begin
          st_d  = RX_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      prev_q <= prev_d;
    end
  end

  assign nrz_o = (st_q == RX_IDLE);
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int unsigned OSR   = OSR_DEF,
  parameter int unsigned PULSE = PULSE_DEF,
  parameter int unsigned SYNC  = SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rx_idle_hi,
  input  logic tick16,
  input  logic tx_nrz,
  output logic ir_tx,
  input  logic ir_rx,
  output logic rx_nrz
);
  logic enc_zero;
  logic pulse_s;
  logic blank;

  irsir_enc #(.OSR(OSR), .PULSE(PULSE)) enc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (enable),
    .tick_i     (tick16),
    .nrz_i      (tx_nrz),
    .ir_o       (ir_tx),
    .zero_bit_o (enc_zero)
  );

  irsir_sync #(.STAGES(SYNC)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ir_rx ^ rx_idle_hi),
    .q_o   (pulse_s)
  );

  assign blank = !tx_nrz || enc_zero;

  irsir_dec #(.OSR(OSR)) dec_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (enable),
    .tick_i  (tick16),
    .pulse_i (pulse_s),
    .blank_i (blank),
    .nrz_o   (rx_nrz)
  );
endmodule

// File: rtl/irsir_codec_chk.sv
module irsir_codec_chk #(
  parameter int unsigned PULSE = 3
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tick16,
  input logic tx_nrz,
  input logic ir_tx,
  input logic rx_nrz
);
  logic [7:0] hi_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_ticks <= '0;
    else if (!ir_tx)                     hi_ticks <= '0;
    else if (tick16 && hi_ticks != 8'hff) hi_ticks <= hi_ticks + 1'b1;
  end

  // R9
  ir_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ir_tx);

  // R9
  rx_idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> rx_nrz);

  // R2
  pulse_only_for_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> $past(tick16 && !tx_nrz));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ticks <= 8'(PULSE));

  // R8
  rx_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick16 && !tx_nrz) |=> rx_nrz);

  // R10
  ir_edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ir_tx) || $fell(ir_tx)) |-> ($past(tick16) || $past(!enable)));

  // R10
  rx_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_nrz) |-> $past(tick16));
endmodule

bind irsir_codec irsir_codec_chk #(.PULSE(PULSE)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .enable (enable),
  .tick16 (tick16),
  .tx_nrz (tx_nrz),
  .ir_tx  (ir_tx),
  .rx_nrz (rx_nrz)
);

// File: tb/irsir_codec_tb_top.sv
`timescale 1ns/1ps
module irsir_codec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic rx_idle_hi = 1'b0;
  logic tick16 = 1'b0;
  logic tx_nrz = 1'b1;
  logic ir_rx = 1'b0;
  logic ir_tx;
  logic rx_nrz;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit pend   = 1'b0;

  typedef struct {
    logic  eir;
    logic  erx;
    string tag;
  } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;

  irsir_codec dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_idle_hi(rx_idle_hi),
    .tick16(tick16), .tx_nrz(tx_nrz), .ir_tx(ir_tx), .ir_rx(ir_rx),
    .rx_nrz(rx_nrz)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic direct(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  // driver: one tick with its inputs and the levels expected after it
  task automatic step(input logic txv, input logic act, input logic eir,
                      input logic erx, input string tag);
    exp_t e;
    @(negedge clk);
    tx_nrz = txv;
    ir_rx  = act ^ rx_idle_hi;
    e.eir = eir; e.erx = erx; e.tag = tag;
    expq.push_back(e);
    repeat (6) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic tx_bit(input logic b, input bit echo, input string tag);
    for (int k = 0; k < 16; k++) begin
      logic p;
      p = (b == 1'b0) && (k < 3);
      step(b, echo ? p : 1'b0, p, 1'b1, tag);
    end
  endtask

  task automatic rx_bit(input logic b, input int width, input string tag);
    for (int k = 0; k < 16; k++)
      step(1'b1, (b == 1'b0) && (k < width), 1'b0, b, tag);
  endtask

  // monitor
  always @(posedge clk) if (tick16) pend <= 1'b1;

  always @(negedge clk) begin
    if (pend) begin
      pend <= 1'b0;
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty ir_tx=%b rx_nrz=%b expected=none", ir_tx, rx_nrz);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (ir_tx !== e.eir || rx_nrz !== e.erx) begin
          fails++;
          $display("FAIL %s ir_tx=%b expected=%b rx_nrz=%b expected=%b",
                   e.tag, ir_tx, e.eir, rx_nrz, e.erx);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    direct(ir_tx, 1'b0, "R1 ir_tx in reset");
    direct(rx_nrz, 1'b1, "R1 rx_nrz in reset");
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    direct(ir_tx, 1'b0, "R1 ir_tx after reset");
    direct(rx_nrz, 1'b1, "R1 rx_nrz after reset");

    // transmit
    tx_bit(1'b1, 0, "R3 one bit");
    tx_bit(1'b1, 0, "R3 one bit");
    tx_bit(1'b0, 0, "R2 zero bit");
    tx_bit(1'b0, 0, "R4 second zero");
    tx_bit(1'b0, 0, "R4 third zero");
    tx_bit(1'b1, 0, "R3 one after zero");
    tx_bit(1'b0, 0, "R4 realign zero");
    tx_bit(1'b1, 0, "R3 trailing one");

    // receive
    rx_bit(1'b1, 3, "R5 idle");
    rx_bit(1'b0, 3, "R5 zero");
    rx_bit(1'b0, 3, "R5 back-to-back zero");
    rx_bit(1'b1, 3, "R5 return to one");
    rx_bit(1'b0, 1, "R6 one-tick pulse");
    rx_bit(1'b1, 1, "R6 after short pulse");

    // between-tick probe
    @(negedge clk);
    tx_nrz = 1'b1;
    ir_rx  = 1'b1 ^ rx_idle_hi;
    begin
      exp_t e;
      e.eir = 1'b0; e.erx = 1'b0; e.tag = "R10 output at tick";
      expq.push_back(e);
    end
    repeat (6) @(negedge clk);
    direct(rx_nrz, 1'b1, "R10 rx_nrz before tick");
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
    for (int k = 1; k < 16; k++) step(1'b1, k < 3, 1'b0, 1'b0, "R10 rest of zero");
    rx_bit(1'b1, 3, "R10 idle");

    // half-duplex echo suppression
    tx_bit(1'b0, 1, "R8 echo of zero");
    tx_bit(1'b0, 1, "R8 echo of zero");
    tx_bit(1'b1, 1, "R8 after echo");
    rx_bit(1'b1, 3, "R8 rx idle after tx");

    // disable mid-pulse
    step(1'b0, 1'b0, 1'b1, 1'b1, "R2 pulse before disable");
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    direct(ir_tx, 1'b0, "R9 ir_tx one cycle after disable");
    tx_nrz = 1'b1;
    enable = 1'b1;
    rx_bit(1'b1, 3, "R9 idle after re-enable");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R5 zero before disable");
    @(negedge clk);
    ir_rx  = rx_idle_hi;
    enable = 1'b0;
    @(negedge clk);
    direct(rx_nrz, 1'b1, "R9 rx_nrz one cycle after disable");

    // disabled: stimulus has no effect at the ports
    for (int k = 0; k < 16; k++) step(1'b0, k < 3, 1'b0, 1'b1, "R9 disabled");

    // inverted detector polarity, changed while disabled
    step(1'b1, 1'b0, 1'b0, 1'b1, "R9 disabled idle");
    rx_idle_hi = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b1, "R9 disabled idle");
    enable = 1'b1;
    tx_bit(1'b1, 0, "R9 idle after re-enable");
    tx_bit(1'b0, 0, "R9 fresh pulse after re-enable");
    tx_bit(1'b1, 0, "R3 one");
    rx_bit(1'b1, 3, "R7 inverted idle");
    rx_bit(1'b0, 3, "R7 inverted zero");
    rx_bit(1'b1, 3, "R7 inverted one");
    rx_bit(1'b0, 1, "R7 inverted short pulse");
    rx_bit(1'b1, 3, "R7 inverted one");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule